// File: doc/BRIEF.md
# Serial Channel Pin Function Multiplexer

This block decides what each of the four general-purpose pins of one serial channel does. A 2-bit mode field per pin either makes the pin an input, with its output driver turned off, or selects one of three driven sources. The sources are the matching output-port bit, the active-low request-to-send signal (pin 1 only), or a transmit or receive clock at 1x or 16x rate. The surrounding channel logic supplies the mode fields, the output-port bits, the request-to-send enable and the clocks. The pad cell returns the sensed pin level.

The receive side of every pin is always live. A pin that drives therefore also feeds its own level back into the input-port readback, the external clock taps and the change detectors on pins 0 and 1. This allows a channel to count or watch its own outputs. The readback is combinational and not latched. The change detectors synchronize pins 0 and 1 and keep a sticky flag per pin, which a read strobe clears.

Top module: `pin_mux_ctrl`

## Requirements
- R1: When a pin's mode field (pin k at bits 2k+1:2k of `pin_mode_i`) is 00, `pad_oe_o[k]` is 0; for 01, 10 or 11 it is 1 once reset has been released.
- R2: Mode 01 drives `port_bits_i[k]` on `pad_out_o[k]`, except on pin 1, where it drives `rts_n_i` when `rts_enable_i` and `port_bits_i[1]` are both 1.
- R3: On pin 3, mode 10 drives the 16x transmit clock and mode 11 the 1x transmit clock; on pin 2, mode 10 drives the 1x receive clock and mode 11 the 16x receive clock.
- R4: On pin 0, mode 10 drives the 1x transmit clock and mode 11 the 16x one; on pin 1, mode 10 drives the 16x receive clock and mode 11 the 1x one.
- R5: `in_port_o` follows the sensed pin levels without latching, with bit 0 = pin 2, bit 1 = pin 0, bit 2 = pin 3 and bit 3 = pin 1, in every mode.
- R6: `tx_clk_tap_o` equals the sensed level of pin 3 and `rx_clk_tap_o` that of pin 2, in every mode, including when the pin drives.
- R7: A level change on pin 0 or 1 sets `cos_flag_o[k]` at the third rising clock edge after the change. The flag stays set until it is cleared.
- R8: A `cos_rd_i` high at a rising edge clears both flags at that edge, unless a change is detected at the same edge, in which case that flag stays set.
- R9: Transitions that a pin drives itself on pins 0 and 1 set the change flags the same way as external ones.
- R10: While reset is asserted and for two clock edges after its release, every `pad_oe_o` bit and every change flag is 0, whatever the mode fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode_i | input | 8 | Per-pin mode fields, pin k at bits 2k+1:2k |
| rts_enable_i | input | 1 | Allows request-to-send on pin 1 |
| port_bits_i | input | 4 | Output-port bit for each pin |
| rts_n_i | input | 1 | Active-low request-to-send from the channel |
| txclk_1x_i | input | 1 | Transmit clock, 1x |
| txclk_16x_i | input | 1 | Transmit clock, 16x |
| rxclk_1x_i | input | 1 | Receive clock, 1x |
| rxclk_16x_i | input | 1 | Receive clock, 16x |
| pad_in_i | input | 4 | Sensed pin levels from the pad cells |
| pad_out_o | output | 4 | Value driven on each pin |
| pad_oe_o | output | 4 | Output driver enable per pin |
| in_port_o | output | 4 | Unlatched input-port readback, reordered |
| tx_clk_tap_o | output | 1 | External transmit clock tap (pin 3) |
| rx_clk_tap_o | output | 1 | External receive clock tap (pin 2) |
| cos_rd_i | input | 1 | Read strobe that clears the change flags |
| cos_flag_o | output | 2 | Sticky change-of-state flags, pins 0 and 1 |

## Verification
On every cycle, the assertions check these properties: the driver enable against each mode field, the pin 1 request-to-send choice, the readback bit order, the clock taps, the stickiness of the change flags and the quiet state during reset. The selection of each clock source by the 10 and 11 encodings, the three-edge latency of change detection and the priority of a new change over a clearing read are shown only by the bench's scenarios. The same holds for transitions a pin drives itself, which the bench models by feeding the pad value back into the block.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NPINS  = 4;
  localparam int MODE_W = 2;
  localparam int NCOS   = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_INPUT = 2'b00,
    PM_PORT  = 2'b01,
    PM_ALT_A = 2'b10,
    PM_ALT_B = 2'b11
  } pin_mode_e;

  // clock vector index: 0 tx 1x, 1 tx 16x, 2 rx 1x, 3 rx 16x
  function automatic int alt_a_src(input int pin);
    case (pin)
      0:       return 0;
      1:       return 3;
      2:       return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int alt_b_src(input int pin);
    case (pin)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      default: return 0;
    endcase
  endfunction

  // which pin lands on each readback bit
  function automatic int rb_pin(input int bitpos);
    case (bitpos)
      0:       return 2;
      1:       return 0;
      2:       return 3;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/pm_pin_src.sv
module pm_pin_src
  import pinmux_pkg::*;
#(
  parameter int PIN_IDX = 0
) (
  input  logic      en_i,
  input  pin_mode_e mode_i,
  input  logic      port_bit_i,
  input  logic      rts_gate_i,
  input  logic      rts_n_i,
  input  logic [3:0] clk_vec_i,
  output logic      drv_o,
  output logic      oe_o
);
  localparam int A_IDX = alt_a_src(PIN_IDX);
  localparam int B_IDX = alt_b_src(PIN_IDX);

  always_comb begin
    oe_o = en_i && (mode_i != PM_INPUT);
    unique case (mode_i)
      PM_PORT:  drv_o = rts_gate_i ? rts_n_i : port_bit_i;
      PM_ALT_A: drv_o = clk_vec_i[A_IDX];
      PM_ALT_B: drv_o = clk_vec_i[B_IDX];
      default:  drv_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pm_cos_detect.sv
module pm_cos_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ok,
  input  logic pin_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic edge_seen;

  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], pin_i};
    prev_d    = sync_q[SYNC_STAGES-1];
    edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;
    if (edge_seen)  flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_mux_ctrl.sv
module pin_mux_ctrl
  import pinmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS*MODE_W-1:0]   pin_mode_i,
  input  logic                      rts_enable_i,
  input  logic [NPINS-1:0]          port_bits_i,
  input  logic                      rts_n_i,
  input  logic                      txclk_1x_i,
  input  logic                      txclk_16x_i,
  input  logic                      rxclk_1x_i,
  input  logic                      rxclk_16x_i,
  input  logic [NPINS-1:0]          pad_in_i,
  output logic [NPINS-1:0]          pad_out_o,
  output logic [NPINS-1:0]          pad_oe_o,
  output logic [NPINS-1:0]          in_port_o,
  output logic                      tx_clk_tap_o,
  output logic                      rx_clk_tap_o,
  input  logic                      cos_rd_i,
  output logic [NCOS-1:0]           cos_flag_o
);
  logic       rst_ok;
  logic [3:0] clk_vec;

  assign clk_vec = {rxclk_16x_i, rxclk_1x_i, txclk_16x_i, txclk_1x_i};

  pm_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic rts_gate;
    assign rts_gate = (g == 1) ? (rts_enable_i & port_bits_i[g]) : 1'b0;

    pm_pin_src #(.PIN_IDX(g)) src_i (
      .en_i       (rst_ok),
      .mode_i     (pin_mode_e'(pin_mode_i[g*MODE_W +: MODE_W])),
      .port_bit_i (port_bits_i[g]),
      .rts_gate_i (rts_gate),
      .rts_n_i    (rts_n_i),
      .clk_vec_i  (clk_vec),
      .drv_o      (pad_out_o[g]),
      .oe_o       (pad_oe_o[g])
    );

    assign in_port_o[g] = pad_in_i[rb_pin(g)];
  end

  for (genvar c = 0; c < NCOS; c++) begin : g_cos
    pm_cos_detect #(.SYNC_STAGES(SYNC_STAGES)) cos_i (
      .clk(clk), .rst_ok(rst_ok), .pin_i(pad_in_i[c]),
      .clr_i(cos_rd_i), .flag_o(cos_flag_o[c])
    );
  end

  assign tx_clk_tap_o = pad_in_i[3];
  assign rx_clk_tap_o = pad_in_i[2];
endmodule

// File: rtl/pin_mux_ctrl_chk.sv
module pin_mux_ctrl_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic [7:0] pin_mode_i,
  input logic       rts_enable_i,
  input logic [3:0] port_bits_i,
  input logic       rts_n_i,
  input logic [3:0] pad_in_i,
  input logic [3:0] pad_out_o,
  input logic [3:0] pad_oe_o,
  input logic [3:0] in_port_o,
  input logic       tx_clk_tap_o,
  input logic       rx_clk_tap_o,
  input logic       cos_rd_i,
  input logic [1:0] cos_flag_o
);
  for (genvar k = 0; k < 4; k++) begin : g_oe
    assert_in_mode_tristate_R1: assert property (@(posedge clk) disable iff (!rst_ok)
      (pin_mode_i[2*k +: 2] == 2'b00) |-> !pad_oe_o[k]);
    assert_out_mode_drives_R1: assert property (@(posedge clk) disable iff (!rst_ok)
      (pin_mode_i[2*k +: 2] != 2'b00) |-> pad_oe_o[k]);
  end

  assert_rts_select_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (pin_mode_i[3:2] == 2'b01 && rts_enable_i && port_bits_i[1]) |-> (pad_out_o[1] == rts_n_i));

  assert_readback_order_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    in_port_o == {pad_in_i[1], pad_in_i[3], pad_in_i[0], pad_in_i[2]});

  assert_clk_taps_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (tx_clk_tap_o == pad_in_i[3]) && (rx_clk_tap_o == pad_in_i[2]));

  for (genvar c = 0; c < 2; c++) begin : g_cos
    assert_cos_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ok)
      (cos_flag_o[c] && !cos_rd_i) |=> cos_flag_o[c]);
  end

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_ok |-> (pad_oe_o == 4'b0000 && cos_flag_o == 2'b00));
endmodule

bind pin_mux_ctrl pin_mux_ctrl_chk chk_i (
  .clk(clk), .rst_ok(rst_ok), .pin_mode_i(pin_mode_i),
  .rts_enable_i(rts_enable_i), .port_bits_i(port_bits_i), .rts_n_i(rts_n_i),
  .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
  .in_port_o(in_port_o), .tx_clk_tap_o(tx_clk_tap_o), .rx_clk_tap_o(rx_clk_tap_o),
  .cos_rd_i(cos_rd_i), .cos_flag_o(cos_flag_o)
);

// File: tb/pin_mux_ctrl_tb_top.sv
module pin_mux_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_mode;
  logic       rts_en, rts_n;
  logic [3:0] port_bits, clks, ext;
  logic [3:0] pad_in, pad_out, pad_oe, in_port;
  logic       tx_tap, rx_tap, cos_rd;
  logic [1:0] cos_flag;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // pad model: a driven pin senses its own value
  assign pad_in = (pad_out & pad_oe) | (ext & ~pad_oe);

  pin_mux_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_mode_i(pin_mode), .rts_enable_i(rts_en),
    .port_bits_i(port_bits), .rts_n_i(rts_n),
    .txclk_1x_i(clks[0]), .txclk_16x_i(clks[1]), .rxclk_1x_i(clks[2]), .rxclk_16x_i(clks[3]),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .in_port_o(in_port),
    .tx_clk_tap_o(tx_tap), .rx_clk_tap_o(rx_tap), .cos_rd_i(cos_rd), .cos_flag_o(cos_flag)
  );

  typedef struct packed {
    logic [7:0] mode;
    logic       rts_en;
    logic [3:0] port;
    logic [3:0] clks;   // {rx16, rx1, tx16, tx1}
    logic       rts_n;
    logic [3:0] exp_oe;
    logic [3:0] exp_o;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h00, 1'b0, 4'b1111, 4'b1111, 1'b0, 4'b0000, 4'b0000},
    '{8'h55, 1'b0, 4'b1010, 4'b0000, 1'b0, 4'b1111, 4'b1010},
    '{8'h55, 1'b1, 4'b1010, 4'b0000, 1'b0, 4'b1111, 4'b1000},
    '{8'h55, 1'b1, 4'b0101, 4'b0000, 1'b1, 4'b1111, 4'b0101},
    '{8'h55, 1'b0, 4'b0010, 4'b0000, 1'b0, 4'b1111, 4'b0010},
    '{8'hAA, 1'b0, 4'b0000, 4'b1001, 1'b0, 4'b1111, 4'b0011},
    '{8'hAA, 1'b0, 4'b0000, 4'b0110, 1'b0, 4'b1111, 4'b1100},
    '{8'hFF, 1'b0, 4'b0000, 4'b1001, 1'b0, 4'b1111, 4'b1100},
    '{8'hFF, 1'b0, 4'b0000, 4'b0110, 1'b0, 4'b1111, 4'b0011},
    '{8'b00110110, 1'b1, 4'b0010, 4'b1001, 1'b0, 4'b0111, 4'b0101}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_mode = 8'hFF; rts_en = 1'b0; rts_n = 1'b1;
    port_bits = 4'h0; clks = 4'h0; ext = 4'h0; cos_rd = 1'b0;
    tick(3);
    // R10: modes all non-zero but reset holds pins as inputs
    check({4'h0, pad_oe}, 8'h00, "R10 oe in reset");
    check({6'h0, cos_flag}, 8'h00, "R10 flags in reset");
    rst_n = 1'b1;
    tick(1);
    check({4'h0, pad_oe}, 8'h00, "R10 oe during release");
    tick(3);
    check({4'h0, pad_oe}, 8'h0F, "R1 oe after release");

    // vector table: R1 enables, R2 R3 R4 sources
    for (int v = 0; v < 10; v++) begin
      pin_mode = VECS[v].mode; rts_en = VECS[v].rts_en; port_bits = VECS[v].port;
      clks = VECS[v].clks; rts_n = VECS[v].rts_n;
      #1;
      check({4'h0, pad_oe}, {4'h0, VECS[v].exp_oe}, "R1 vector oe");
      check({4'h0, pad_out & pad_oe}, {4'h0, VECS[v].exp_o}, "R2 R3 R4 vector source");
      tick(1);
    end

    // R5 readback order and R6 taps with all pins as inputs
    pin_mode = 8'h00; rts_en = 1'b0; port_bits = 4'h0; clks = 4'h0;
    ext = 4'b0001; #1; check({4'h0, in_port}, 8'h02, "R5 pin0 to bit1");
    ext = 4'b0100; #1; check({4'h0, in_port}, 8'h01, "R5 pin2 to bit0");
    check({7'h0, rx_tap}, 8'h01, "R6 rx tap");
    ext = 4'b1000; #1; check({4'h0, in_port}, 8'h04, "R5 pin3 to bit2");
    check({7'h0, tx_tap}, 8'h01, "R6 tx tap");
    ext = 4'b0010; #1; check({4'h0, in_port}, 8'h08, "R5 pin1 to bit3");
    // R5 R6 loopback of a driven pin 3
    ext = 4'b0000; pin_mode = 8'b01_00_00_00; port_bits = 4'b1000; #1;
    check({7'h0, tx_tap}, 8'h01, "R6 tx tap sees own drive");
    check({4'h0, in_port}, 8'h04, "R5 readback sees own drive");

    // change detection
    pin_mode = 8'h00; port_bits = 4'h0; ext = 4'h0;
    tick(5);
    cos_rd = 1'b1; tick(1); cos_rd = 1'b0;
    check({6'h0, cos_flag}, 8'h00, "R8 cleared baseline");
    ext = 4'b0001;
    tick(2);
    check({6'h0, cos_flag}, 8'h00, "R7 not yet after two edges");
    tick(1);
    check({6'h0, cos_flag}, 8'h01, "R7 set at third edge");
    tick(4);
    check({6'h0, cos_flag}, 8'h01, "R7 sticky");
    cos_rd = 1'b1; tick(1); cos_rd = 1'b0;
    check({6'h0, cos_flag}, 8'h00, "R8 read clears");
    // R8 change at the same edge as a read
    ext = 4'b0000;
    tick(2);
    cos_rd = 1'b1; tick(1); cos_rd = 1'b0;
    check({6'h0, cos_flag}, 8'h01, "R8 new change wins over read");
    cos_rd = 1'b1; tick(1); cos_rd = 1'b0;
    // R9 pin 1 drives its own transition
    pin_mode = 8'b00_00_01_00; port_bits = 4'b0010;
    tick(3);
    check({6'h0, cos_flag}, 8'h02, "R9 self-driven change");
    check({4'h0, pad_oe}, 8'h02, "R1 pin1 driving");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule